// File: doc/BRIEF.md
# Full-Duplex DAC Serial Transfer Engine

This block runs one full-duplex serial exchange with a register-based DAC. The host places a 32-bit word on the transmit input and raises its select request. It then raises arm. The engine keeps the serial clock high through a short setup wait. It then runs 24 clock periods. In each period the clock goes low, the next outgoing bit appears, and the incoming bit is taken at the end of the low half before the clock returns high.

The outgoing bits are the top 24 bits of the host word, sent most significant first. The 24 incoming bits form a result whose first bit is the most significant. This result appears zero-extended on a 32-bit output. A done flag rises when the last period ends. The done flag and the result both hold until the host drops arm. The frame-select pin is driven only by the host's select request and never by the engine.

Top module: `dac_xfer_engine`

## Requirements
- R1: After reset the serial clock is high, done is low, the result word is zero and MOSI is low.
- R2: The serial clock stays high from the arm request until the first falling edge. That edge comes exactly SETUP_CYC+1 clock cycles after arm is first seen high in the idle state.
- R3: A transfer has exactly 24 low phases of the serial clock. Each low phase and each high phase between bits lasts HALF_CYC clock cycles.
- R4: MOSI carries transmit bits 31 down to 8, one per period, starting with bit 31. MOSI changes only at a falling clock edge and is stable while the clock is high within a transfer.
- R5: MISO is sampled at the last clock cycle of each low phase. The first sampled bit ends up in result bit 23 and the last in bit 0.
- R6: Result bits 31 to 24 are always zero.
- R7: Done rises after the 24th high phase. While arm stays high, done stays high and the result stays unchanged.
- R8: One cycle after arm is seen low in the done state, done is low. No new transfer starts until arm is raised again.
- R9: The frame-select pin is low exactly when the host select request is high. A transfer runs to completion even when select is low.
- R10: The transmit word is captured when the transfer starts, so changing it during a transfer has no effect on MOSI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_word_i | input | 32 | Word whose top 24 bits are sent |
| sel_i | input | 1 | Host frame-select request, active high |
| arm_i | input | 1 | Start request, held high until done is consumed |
| done_o | output | 1 | Transfer finished, held while arm is high |
| rx_word_o | output | 32 | Zero-extended 24-bit received value |
| sck_o | output | 1 | Serial clock, idles high |
| sync_n_o | output | 1 | Frame select to the DAC, active low |
| mosi_o | output | 1 | Serial data to the DAC |
| miso_i | input | 1 | Serial data from the DAC |

## Verification
The bench builds the engine with HALF_CYC of 3 and SETUP_CYC of 2. With these values a full transfer takes about 150 cycles, so many word patterns fit in a short run. A half period longer than one cycle shows whether MOSI stays stable across several high cycles. It also shows whether MISO is taken at the end of the low phase rather than the start. The short setup makes the exact edge count from arm to the first falling edge easy to check.

// File: rtl/dac_xfer_pkg.sv
package dac_xfer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_LOW   = 3'd2,
    ST_HIGH  = 3'd3,
    ST_DONE  = 3'd4
  } xfer_state_e;
endpackage

// File: rtl/dac_xfer_timer.sv
module dac_xfer_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load || !zero;

  always_comb begin
    cnt_d = cnt_q;
    if (load)       cnt_d = load_val;
    else if (!zero) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dac_xfer_shifter.sv
module dac_xfer_shifter #(
  parameter int NBITS  = 24,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              shift_tx,
  input  logic              cap_rx,
  input  logic              miso,
  output logic              mosi_bit,
  output logic [NBITS-1:0]  rx_bits
);
  logic [NBITS-1:0] tx_q, tx_d, rx_q, rx_d;
  logic             tx_en, rx_en;

  assign tx_en = load || shift_tx;
  assign rx_en = load || cap_rx;

  always_comb begin
    tx_d = tx_q;
    if (load)          tx_d = tx_word[WORD_W-1 -: NBITS];
    else if (shift_tx) tx_d = {tx_q[NBITS-2:0], 1'b0};
  end

  always_comb begin
    rx_d = rx_q;
    if (load)        rx_d = '0;
    else if (cap_rx) rx_d = {rx_q[NBITS-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tx_q <= '0;
    else if (tx_en) tx_q <= tx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rx_q <= '0;
    else if (rx_en) rx_q <= rx_d;
  end

  assign mosi_bit = tx_q[NBITS-1];
  assign rx_bits  = rx_q;
endmodule

// File: rtl/dac_xfer_ctrl.sv
module dac_xfer_ctrl
  import dac_xfer_pkg::*;
#(
  parameter int HALF_CYC  = 4,
  parameter int SETUP_CYC = 3,
  parameter int NBITS     = 24,
  parameter int CNT_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             tmr_zero,
  output xfer_state_e      state,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             sh_load,
  output logic             sh_shift,
  output logic             sh_cap
);
  localparam int BIT_W = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(NBITS - 1);
  localparam logic [CNT_W-1:0] HALF_M1  = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] SETUP_M1 = CNT_W'(SETUP_CYC - 1);

  xfer_state_e      st_q, st_d;
  logic [BIT_W-1:0] bit_q, bit_d;

  always_comb begin
    st_d     = st_q;
    bit_d    = bit_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    sh_cap   = 1'b0;
    case (st_q)
      ST_IDLE: if (arm) begin
        st_d     = ST_SETUP;
        tmr_load = 1'b1;
        tmr_val  = SETUP_M1;
        sh_load  = 1'b1;
        bit_d    = '0;
      end
      ST_SETUP: if (tmr_zero) begin
        st_d     = ST_LOW;
        tmr_load = 1'b1;
        tmr_val  = HALF_M1;
      end
      ST_LOW: if (tmr_zero) begin
        st_d     = ST_HIGH;
        tmr_load = 1'b1;
        tmr_val  = HALF_M1;
        sh_cap   = 1'b1;
      end
      ST_HIGH: if (tmr_zero) begin
        if (bit_q == LAST_BIT) begin
          st_d = ST_DONE;
        end else begin
          st_d     = ST_LOW;
          tmr_load = 1'b1;
          tmr_val  = HALF_M1;
          sh_shift = 1'b1;
          bit_d    = bit_q + BIT_W'(1);
        end
      end
      ST_DONE: if (!arm) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      bit_q <= '0;
    end else begin
      st_q  <= st_d;
      bit_q <= bit_d;
    end
  end

  assign state = st_q;

  // R3
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOW) |-> (bit_q <= LAST_BIT));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE && arm) |=> (st_q == ST_DONE));
endmodule

// File: rtl/dac_xfer_engine.sv
module dac_xfer_engine
  import dac_xfer_pkg::*;
#(
  parameter int HALF_CYC  = 125,
  parameter int SETUP_CYC = 5,
  parameter int NBITS     = 24,
  parameter int WORD_W    = 32
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic              sel_i,
  input  logic              arm_i,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              sck_o,
  output logic              sync_n_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int MAXV  = (HALF_CYC > SETUP_CYC) ? HALF_CYC : SETUP_CYC;
  localparam int CNT_W = $clog2(MAXV + 1);
  localparam int PAD_W = WORD_W - NBITS;

  logic rst_s1_q, rst_n;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1_q <= 1'b0;
      rst_n    <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_n    <= rst_s1_q;
    end
  end

  xfer_state_e      state;
  logic             tmr_load, tmr_zero, sh_load, sh_shift, sh_cap, mosi_bit;
  logic [CNT_W-1:0] tmr_val;
  logic [NBITS-1:0] rx_bits;

  dac_xfer_ctrl #(
    .HALF_CYC(HALF_CYC), .SETUP_CYC(SETUP_CYC), .NBITS(NBITS), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm_i), .tmr_zero(tmr_zero),
    .state(state), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .sh_load(sh_load), .sh_shift(sh_shift), .sh_cap(sh_cap)
  );

  dac_xfer_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .zero(tmr_zero)
  );

  dac_xfer_shifter #(.NBITS(NBITS), .WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .tx_word(tx_word_i),
    .shift_tx(sh_shift), .cap_rx(sh_cap), .miso(miso_i),
    .mosi_bit(mosi_bit), .rx_bits(rx_bits)
  );

  logic active;
  assign active    = (state == ST_LOW) || (state == ST_HIGH);
  assign sck_o     = (state != ST_LOW);
  assign mosi_o    = active ? mosi_bit : 1'b0;
  assign done_o    = (state == ST_DONE);
  assign rx_word_o = {{PAD_W{1'b0}}, rx_bits};
  assign sync_n_o  = ~sel_i;

  // R4
  mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HIGH && $past(state) == ST_HIGH) |-> $stable(mosi_o));

  // R5
  cap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_cap |-> !sck_o);

  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && arm_i) |=> $stable(rx_word_o));

  // R8
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !arm_i) |=> !done_o);
endmodule

// File: tb/dac_xfer_engine_bench.sv
module dac_xfer_engine_bench;
  localparam int HALF  = 3;
  localparam int SETUP = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] tx_word;
  logic        sel, arm, miso;
  logic        done, sck, sync_n, mosi;
  logic [31:0] rx_word;

  always #2 clk = ~clk;

  dac_xfer_engine #(.HALF_CYC(HALF), .SETUP_CYC(SETUP)) u_dac_xfer_engine (
    .clk(clk), .rst_ni(rst_n), .tx_word_i(tx_word), .sel_i(sel),
    .arm_i(arm), .done_o(done), .rx_word_o(rx_word), .sck_o(sck),
    .sync_n_o(sync_n), .mosi_o(mosi), .miso_i(miso)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [23:0] mosi;
    logic [23:0] rx;
  } exp_t;
  exp_t sb_q[$];

  int          cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // slave model and pin monitor
  logic [23:0] slave_word;
  logic [23:0] mosi_cap;
  int          idx, falls, low_len, first_fall, arm_cyc;
  logic        sck_prev, done_prev;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sck_prev && !sck) begin
        if (falls == 0) first_fall = cyc;
        falls++;
        if (idx < 24) miso <= slave_word[23-idx];
        idx++;
        low_len = 1;
      end else if (!sck) begin
        low_len++;
      end else if (!sck_prev && sck) begin
        mosi_cap = {mosi_cap[22:0], mosi};
        // R3 low phase length
        check(low_len == HALF, "R3 low phase", low_len, HALF);
      end
      if (done && !done_prev) begin
        exp_t e;
        if (sb_q.size() == 0) begin
          check(0, "R7 unexpected done", 1, 0);
        end else begin
          e = sb_q.pop_front();
          check(rx_word == {8'h00, e.rx}, "R5 rx word", rx_word, {8'h00, e.rx});
          check(rx_word[31:24] == 8'h00, "R6 upper zero", rx_word[31:24], 0);
          check(mosi_cap == e.mosi, "R4 R10 mosi bits", mosi_cap, e.mosi);
          check(falls == 24, "R3 edge count", falls, 24);
          check(first_fall - arm_cyc == SETUP + 1, "R2 setup gap",
                first_fall - arm_cyc, SETUP + 1);
        end
      end
      sck_prev  = sck;
      done_prev = done;
    end else begin
      sck_prev  = 1'b1;
      done_prev = 1'b0;
    end
  end

  task automatic run_xfer(input logic [31:0] tx, input logic [23:0] slv,
                          input logic s, input bit corrupt);
    exp_t e;
    logic [31:0] held;
    int n;
    slave_word = slv;
    idx = 0; falls = 0; mosi_cap = '0;
    e.mosi = tx[31:8];
    e.rx   = slv;
    sb_q.push_back(e);
    @(negedge clk);
    sel = s;
    tx_word = tx;
    @(negedge clk);
    // R9
    check(sync_n == !s, "R9 frame select", sync_n, !s);
    check(sck == 1'b1, "R2 idle high", sck, 1);
    arm = 1'b1;
    arm_cyc = cyc;
    if (corrupt) begin
      repeat (20) @(negedge clk);
      tx_word = ~tx;  // R10
    end
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, "R7 done seen", done, 1);
    held = rx_word;
    repeat (5) @(negedge clk);
    check(done == 1'b1, "R7 done held", done, 1);
    check(rx_word == held, "R7 rx held", rx_word, held);
    arm = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(done == 1'b0, "R8 done cleared", done, 0);
    n = falls;
    repeat (10) @(negedge clk);
    check(falls == n && sck, "R8 no restart", falls, n);
  endtask

  initial begin
    rst_n = 1'b0; tx_word = '0; sel = 1'b0; arm = 1'b0; miso = 1'b0;
    slave_word = '0; idx = 0; falls = 0; mosi_cap = '0;
    low_len = 0; first_fall = 0; arm_cyc = 0;
    repeat (4) @(negedge clk);
    // R1
    check(sck == 1'b1, "R1 sck reset", sck, 1);
    check(done == 1'b0, "R1 done reset", done, 0);
    check(rx_word == '0, "R1 rx reset", rx_word, 0);
    check(mosi == 1'b0, "R1 mosi reset", mosi, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    run_xfer(32'hA5C3_7E11, 24'h3C_96F1, 1'b1, 0);
    run_xfer(32'hFFFF_FF00, 24'h00_0001, 1'b1, 0);
    run_xfer(32'h0000_00FF, 24'hFF_FFFF, 1'b1, 1);
    run_xfer(32'h8000_0000, 24'h80_0000, 1'b0, 0);
    run_xfer(32'h1234_5678, 24'h5A_A55A, 1'b1, 1);
    check(sb_q.size() == 0, "R7 scoreboard drained", sb_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R7 watchdog actual=%h expected=%h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule